// File: doc/BRIEF.md
# Register-Write Command Packer

This block turns a stream of register write requests into a packed list of 64-bit instructions held in an internal command memory of 32-bit words. A request carries a 20-bit register offset, a 32-bit value and a 32-bit write mask. Each instruction takes two words. The value sits in the even word and a header sits in the odd word above it. The header holds the opcode in bits 31:24, the byte enables in bits 23:20 and the offset in bits 19:0. A single write uses opcode 0x01 and an indexed burst uses opcode 0x09.

Back-to-back full-mask writes to one register are folded into a single indexed burst. The packer rewrites the two-word instruction it has already emitted, keeps the burst count word current, and keeps the zero padding correct when the burst holds an odd number of words. A finish strobe pads the list with zero words up to the next 64-byte (16-word) boundary and reports the final tail in bytes. A clear strobe empties the list. A request that does not fit is dropped and flagged. A consumer reads the list back through a word read port.

Top module: `cmd_packer`

## Requirements
- R1: The byte enables of a single write are derived from the mask one byte lane at a time. Header bit 20+k is set when any bit of mask byte k (bits 8k+7:8k) is set.
- R2: A request whose mask is not all ones is always emitted as a new single write with its derived enables. It never joins an earlier instruction, and a later full-mask write to the same register never joins it.
- R3: A full-mask request that cannot be merged is emitted at the first even word index at or above the write pointer. The value goes to that index and the header {0x01, 0xF, offset} goes to the index above it. The pointer then advances by two past that pair.
- R4: A full-mask request to the same register as a preceding full-enable single write converts that write in place. The word at the start index becomes the count 2. The next word becomes {0x09, 0x0, offset}. The old value moves to start+2 and the new value goes to start+3.
- R5: A full-mask request to the same register as a preceding indexed burst stores the value at the write pointer and increments the count word at the burst's start index.
- R6: When an append leaves the write pointer odd, the word at the pointer is written as zero.
- R7: When the list is empty, no merge is made, whatever the memory holds. The first request always forms a fresh two-word instruction.
- R8: A request that arrives while the write pointer exceeds capacity minus 2 words is dropped. Nothing is written, the pointer is unchanged, and `overflow` pulses for one cycle.
- R9: On finish, the write pointer is rounded up to a multiple of 16 words. Every word in the gap is zeroed, `finish_done` pulses for one cycle and `tail_bytes` shows the new pointer times four. An already aligned pointer, including zero, is left as it is.
- R10: Clear empties the list and has priority over finish, which has priority over a request. A strobe that loses to a higher one in the same cycle has no effect.
- R11: After a finish, the next request starts a new instruction even if it targets the register of the last instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Write request strobe |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Value to write |
| req_mask | input | 32 | Bit mask of the write |
| finish | input | 1 | Pad to a 16-word boundary and report the tail |
| clear | input | 1 | Empty the command list |
| rd_addr | input | $clog2(CAP_WORDS) | Command memory word read address |
| rd_data | output | 32 | Command memory word at rd_addr |
| overflow | output | 1 | One-cycle pulse: request dropped for lack of room |
| finish_done | output | 1 | One-cycle pulse: finish completed |
| tail_bytes | output | $clog2(CAP_WORDS)+3 | Byte tail reported by the last finish |

## Verification
Every cycle, the assertions check the write pointer's behaviour. It stays within capacity, it holds still on a dropped request and grows on an accepted one, it returns to zero on clear, and it lands on a 16-word boundary with a matching tail whenever finish completes. They also check that an empty list always yields a two-word instruction. Only the bench's scenarios can show the memory contents: the lane-by-lane enables, the in-place rewrite into a burst, the count updates, the zero padding over stale data and the priority among strobes. These are read back through the read port and compared with an independent model.

// File: rtl/cmdpk_pkg.sv
package cmdpk_pkg;
  localparam int WORD_W      = 32;
  localparam int OFF_W       = 20;
  localparam int BE_W        = WORD_W / 8;
  localparam int OP_W        = WORD_W - BE_W - OFF_W;
  localparam int ALIGN_WORDS = 16;
  localparam int NPORT       = 4;

  localparam logic [OP_W-1:0] OP_SINGLE = 8'h01;
  localparam logic [OP_W-1:0] OP_BURST  = 8'h09;

  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_FULL  = 2'd1,
    LK_BURST = 2'd2,
    LK_PART  = 2'd3
  } last_kind_e;

  function automatic logic [WORD_W-1:0] make_hdr(
    input logic [OP_W-1:0]  op,
    input logic [BE_W-1:0]  be,
    input logic [OFF_W-1:0] off
  );
    return {op, be, off};
  endfunction
endpackage

// File: rtl/cp_lane_enable.sv
module cp_lane_enable #(
  parameter int W = 32
) (
  input  logic [W-1:0]     mask_i,
  output logic [W/8-1:0]   be_o,
  output logic             full_o
);
  localparam int LANES = W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_o[g] = |mask_i[g*8 +: 8];
  end

  assign full_o = &mask_i;
endmodule

// File: rtl/cp_store.sv
module cp_store
  import cmdpk_pkg::*;
#(
  parameter int CAP_WORDS = 64,
  localparam int IDX_W = $clog2(CAP_WORDS),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic                              clk,
  input  logic [NPORT-1:0]                  wr_en_i,
  input  logic [NPORT-1:0][IDX_W-1:0]       wr_addr_i,
  input  logic [NPORT-1:0][WORD_W-1:0]      wr_data_i,
  input  logic                              zero_en_i,
  input  logic [PTR_W-1:0]                  zero_lo_i,
  input  logic [PTR_W-1:0]                  zero_hi_i,
  input  logic [IDX_W-1:0]                  rd_addr_i,
  output logic [WORD_W-1:0]                 rd_data_o
);
  logic [CAP_WORDS-1:0][WORD_W-1:0] words;

  for (genvar i = 0; i < CAP_WORDS; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              in_gap;

    assign in_gap = zero_en_i && (PTR_W'(i) >= zero_lo_i) && (PTR_W'(i) < zero_hi_i);

    always_ff @(posedge clk) begin
      if (in_gap) begin
        word_q <= '0;
      end
      for (int p = 0; p < NPORT; p++) begin
        if (wr_en_i[p] && (wr_addr_i[p] == IDX_W'(i))) begin
          word_q <= wr_data_i[p];
        end
      end
    end

    assign words[i] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];
endmodule

// File: rtl/cp_control.sv
module cp_control
  import cmdpk_pkg::*;
#(
  parameter int CAP_WORDS = 64,
  localparam int IDX_W = $clog2(CAP_WORDS),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  input  logic [OFF_W-1:0]              req_offset_i,
  input  logic [WORD_W-1:0]             req_value_i,
  input  logic [BE_W-1:0]               req_be_i,
  input  logic                          req_full_i,
  input  logic                          finish_i,
  input  logic                          clear_i,
  output logic [NPORT-1:0]              wr_en_o,
  output logic [NPORT-1:0][IDX_W-1:0]   wr_addr_o,
  output logic [NPORT-1:0][WORD_W-1:0]  wr_data_o,
  output logic                          zero_en_o,
  output logic [PTR_W-1:0]              zero_lo_o,
  output logic [PTR_W-1:0]              zero_hi_o,
  output logic [PTR_W-1:0]              free_o,
  output logic                          ovf_o,
  output logic                          done_o,
  output logic [PTR_W+1:0]              tail_o
);
  localparam logic [PTR_W-1:0] LIMIT    = PTR_W'(CAP_WORDS - 2);
  localparam logic [PTR_W-1:0] ALN_MASK = PTR_W'(ALIGN_WORDS - 1);

  logic [PTR_W-1:0]  free_q, free_d;
  logic [IDX_W-1:0]  start_q, start_d;
  last_kind_e        kind_q, kind_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [WORD_W-1:0] val_q, val_d;
  logic [PTR_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              done_q, done_d;
  logic [PTR_W+1:0]  tail_q, tail_d;

  logic [PTR_W-1:0]  aligned;
  logic [PTR_W-1:0]  even_ptr;
  logic              same_reg;

  assign aligned  = (free_q + ALN_MASK) & ~ALN_MASK;
  assign even_ptr = free_q + PTR_W'(free_q[0]);
  assign same_reg = req_full_i && (req_offset_i == off_q);

  always_comb begin
    free_d    = free_q;
    start_d   = start_q;
    kind_d    = kind_q;
    off_d     = off_q;
    val_d     = val_q;
    cnt_d     = cnt_q;
    ovf_d     = 1'b0;
    done_d    = 1'b0;
    tail_d    = tail_q;
    wr_en_o   = '0;
    wr_addr_o = '0;
    wr_data_o = '0;
    zero_en_o = 1'b0;
    zero_lo_o = free_q;
    zero_hi_o = aligned;

    if (clear_i) begin
      free_d = '0;
      kind_d = LK_NONE;
    end else if (finish_i) begin
      zero_en_o = 1'b1;
      free_d    = aligned;
      kind_d    = LK_NONE;
      done_d    = 1'b1;
      tail_d    = {aligned, 2'b00};
    end else if (req_valid_i) begin
      if (free_q > LIMIT) begin
        ovf_d = 1'b1;
      end else if (same_reg && (kind_q == LK_FULL)) begin
        wr_en_o      = '1;
        wr_addr_o[0] = start_q;
        wr_data_o[0] = WORD_W'(2);
        wr_addr_o[1] = start_q + IDX_W'(1);
        wr_data_o[1] = make_hdr(OP_BURST, '0, req_offset_i);
        wr_addr_o[2] = start_q + IDX_W'(2);
        wr_data_o[2] = val_q;
        wr_addr_o[3] = start_q + IDX_W'(3);
        wr_data_o[3] = req_value_i;
        free_d       = PTR_W'(start_q) + PTR_W'(4);
        kind_d       = LK_BURST;
        cnt_d        = PTR_W'(2);
      end else if (same_reg && (kind_q == LK_BURST)) begin
        wr_en_o[0]   = 1'b1;
        wr_addr_o[0] = free_q[IDX_W-1:0];
        wr_data_o[0] = req_value_i;
        wr_en_o[1]   = 1'b1;
        wr_addr_o[1] = start_q;
        wr_data_o[1] = WORD_W'(cnt_q) + WORD_W'(1);
        wr_en_o[2]   = ~free_q[0];
        wr_addr_o[2] = free_q[IDX_W-1:0] + IDX_W'(1);
        wr_data_o[2] = '0;
        free_d       = free_q + PTR_W'(1);
        cnt_d        = cnt_q + PTR_W'(1);
      end else begin
        wr_en_o[0]   = 1'b1;
        wr_addr_o[0] = even_ptr[IDX_W-1:0];
        wr_data_o[0] = req_value_i;
        wr_en_o[1]   = 1'b1;
        wr_addr_o[1] = even_ptr[IDX_W-1:0] + IDX_W'(1);
        wr_data_o[1] = make_hdr(OP_SINGLE, req_be_i, req_offset_i);
        start_d      = even_ptr[IDX_W-1:0];
        free_d       = even_ptr + PTR_W'(2);
        kind_d       = req_full_i ? LK_FULL : LK_PART;
        off_d        = req_offset_i;
        val_d        = req_value_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q  <= '0;
      start_q <= '0;
      kind_q  <= LK_NONE;
      off_q   <= '0;
      val_q   <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
      tail_q  <= '0;
    end else begin
      free_q  <= free_d;
      start_q <= start_d;
      kind_q  <= kind_d;
      off_q   <= off_d;
      val_q   <= val_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
      tail_q  <= tail_d;
    end
  end

  assign free_o = free_q;
  assign ovf_o  = ovf_q;
  assign done_o = done_q;
  assign tail_o = tail_q;
endmodule

// File: rtl/cmd_packer.sv
module cmd_packer
  import cmdpk_pkg::*;
#(
  parameter int CAP_WORDS = 64,
  localparam int IDX_W = $clog2(CAP_WORDS),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [19:0]        req_offset,
  input  logic [31:0]        req_value,
  input  logic [31:0]        req_mask,
  input  logic               finish,
  input  logic               clear,
  input  logic [IDX_W-1:0]   rd_addr,
  output logic [31:0]        rd_data,
  output logic               overflow,
  output logic               finish_done,
  output logic [PTR_W+1:0]   tail_bytes
);
  logic [1:0]                   rsync_q;
  logic                         rst_n_int;
  logic [BE_W-1:0]              be;
  logic                         full;
  logic [NPORT-1:0]             wr_en;
  logic [NPORT-1:0][IDX_W-1:0]  wr_addr;
  logic [NPORT-1:0][WORD_W-1:0] wr_data;
  logic                         zero_en;
  logic [PTR_W-1:0]             zero_lo;
  logic [PTR_W-1:0]             zero_hi;
  logic [PTR_W-1:0]             free_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  cp_lane_enable #(.W(WORD_W)) u_lanes (
    .mask_i (req_mask),
    .be_o   (be),
    .full_o (full)
  );

  cp_control #(.CAP_WORDS(CAP_WORDS)) u_ctrl (
    .clk          (clk),
    .rst_ni       (rst_n_int),
    .req_valid_i  (req_valid),
    .req_offset_i (req_offset),
    .req_value_i  (req_value),
    .req_be_i     (be),
    .req_full_i   (full),
    .finish_i     (finish),
    .clear_i      (clear),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .zero_en_o    (zero_en),
    .zero_lo_o    (zero_lo),
    .zero_hi_o    (zero_hi),
    .free_o       (free_w),
    .ovf_o        (overflow),
    .done_o       (finish_done),
    .tail_o       (tail_bytes)
  );

  cp_store #(.CAP_WORDS(CAP_WORDS)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .zero_en_i (zero_en),
    .zero_lo_i (zero_lo),
    .zero_hi_i (zero_hi),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/cmd_packer_checker.sv
module cmd_packer_checker #(
  parameter int CAP_WORDS = 64,
  localparam int IDX_W = $clog2(CAP_WORDS),
  localparam int PTR_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             req_valid,
  input logic             finish,
  input logic             clear,
  input logic [PTR_W-1:0] free_w,
  input logic             overflow,
  input logic             finish_done,
  input logic [PTR_W+1:0] tail_bytes
);
  logic accept, refuse;
  assign accept = req_valid && !clear && !finish && (free_w <= PTR_W'(CAP_WORDS - 2));
  assign refuse = req_valid && !clear && !finish && (free_w >  PTR_W'(CAP_WORDS - 2));

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    free_w <= PTR_W'(CAP_WORDS)); // R8

  AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    refuse |=> overflow && $stable(free_w) && !finish_done); // R8

  AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> !overflow && (free_w > $past(free_w))); // R3

  AST_EMPTY_FRESH: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && (free_w == '0)) |=> (free_w == PTR_W'(2))); // R7

  AST_FINISH_ALIGN: assert property (@(posedge clk) disable iff (!rst_ni)
    finish_done |-> (free_w[3:0] == 4'd0) && (tail_bytes == {free_w, 2'b00})); // R9

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
    clear |=> (free_w == '0) && !overflow && !finish_done); // R10

  AST_FINISH_OVER_REQ: assert property (@(posedge clk) disable iff (!rst_ni)
    (finish && !clear) |=> finish_done && !overflow); // R10
endmodule

bind cmd_packer cmd_packer_checker #(.CAP_WORDS(CAP_WORDS)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_n_int),
  .req_valid   (req_valid),
  .finish      (finish),
  .clear       (clear),
  .free_w      (free_w),
  .overflow    (overflow),
  .finish_done (finish_done),
  .tail_bytes  (tail_bytes)
);

// File: tb/cmd_packer_bench.sv
module cmd_packer_bench;
  localparam int TCLK  = 10;
  localparam int CAP   = 32;
  localparam int IDX_W = $clog2(CAP);
  localparam int PTR_W = IDX_W + 1;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [19:0]      req_offset;
  logic [31:0]      req_value;
  logic [31:0]      req_mask;
  logic             finish;
  logic             clear;
  logic [IDX_W-1:0] rd_addr;
  logic [31:0]      rd_data;
  logic             overflow;
  logic             finish_done;
  logic [PTR_W+1:0] tail_bytes;

  cmd_packer #(.CAP_WORDS(CAP)) u_cmd_packer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_value(req_value), .req_mask(req_mask), .finish(finish), .clear(clear),
    .rd_addr(rd_addr), .rd_data(rd_data), .overflow(overflow),
    .finish_done(finish_done), .tail_bytes(tail_bytes)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit ended    = 0;

  // reference model of the command list, built from the requirements
  logic [31:0] m_mem [CAP];
  int          m_free, m_start, m_kind, m_cnt;
  logic [19:0] m_off;
  logic [31:0] m_val;
  int          sbq[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [31:0] d);
    m_mem[a] = d;
    sbq.push_back(a);
  endtask

  task automatic model_req(input logic [19:0] off, input logic [31:0] val,
                           input logic [31:0] mask, output bit ovf);
    logic [3:0] be;
    bit full;
    int e;
    be   = {|mask[31:24], |mask[23:16], |mask[15:8], |mask[7:0]};
    full = (mask == 32'hFFFF_FFFF);
    ovf  = 0;
    if (m_free > CAP - 2) begin
      ovf = 1;
    end else if (full && m_kind == 1 && off == m_off) begin
      put(m_start, 32'd2);
      put(m_start + 1, {8'h09, 4'h0, off});
      put(m_start + 2, m_val);
      put(m_start + 3, val);
      m_free = m_start + 4; m_kind = 2; m_cnt = 2;
    end else if (full && m_kind == 2 && off == m_off) begin
      put(m_free, val);
      m_cnt++;
      put(m_start, 32'(m_cnt));
      m_free++;
      if (m_free % 2 == 1) put(m_free, 32'd0);
    end else begin
      e = m_free + (m_free % 2);
      put(e, val);
      put(e + 1, {8'h01, be, off});
      m_start = e; m_free = e + 2; m_kind = full ? 1 : 3;
      m_off = off; m_val = val;
    end
  endtask

  task automatic model_finish(output int tail);
    int al;
    al = ((m_free + 15) / 16) * 16;
    for (int a = m_free; a < al; a++) put(a, 32'd0);
    m_free = al; m_kind = 0;
    tail = al * 4;
  endtask

  // monitor side of the scoreboard: pop each touched word and compare
  task automatic drain(input string tag);
    int a;
    while (sbq.size() > 0) begin
      a = sbq.pop_front();
      rd_addr = IDX_W'(a);
      #1;
      chk(rd_data === m_mem[a], $sformatf("%s word %0d", tag, a), rd_data, m_mem[a]);
    end
  endtask

  // driver: push expectations, apply one operation, then compare
  task automatic do_op(input bit rv, input logic [19:0] off, input logic [31:0] val,
                       input logic [31:0] mask, input bit fin, input bit clr, input string tag);
    bit eo, ed;
    int et;
    eo = 0; ed = 0; et = 0;
    if (clr) begin
      m_free = 0; m_kind = 0;
    end else if (fin) begin
      model_finish(et); ed = 1;
    end else if (rv) begin
      model_req(off, val, mask, eo);
    end
    @(negedge clk);
    req_valid = rv; req_offset = off; req_value = val; req_mask = mask;
    finish = fin; clear = clr;
    @(negedge clk);
    req_valid = 0; finish = 0; clear = 0;
    chk(overflow === eo, {tag, " overflow"}, overflow, eo);
    chk(finish_done === ed, {tag, " finish_done"}, finish_done, ed);
    if (ed) chk(int'(tail_bytes) == et, {tag, " tail"}, tail_bytes, et);
    drain(tag);
  endtask

  localparam logic [19:0] REG_A = 20'h0010F;
  localparam logic [19:0] REG_B = 20'h002A4;
  localparam logic [19:0] REG_C = 20'h00003;
  localparam logic [31:0] FULL  = 32'hFFFF_FFFF;

  initial begin
    #(TCLK * 100000);
    if (!ended) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_offset = '0; req_value = '0; req_mask = '0;
    finish = 0; clear = 0; rd_addr = '0;
    m_free = 0; m_start = 0; m_kind = 0; m_cnt = 0; m_off = '0; m_val = '0;
    for (int i = 0; i < CAP; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    chk(overflow === 1'b0, "reset overflow", overflow, 0);
    chk(finish_done === 1'b0, "reset finish_done", finish_done, 0);
    chk(tail_bytes === '0, "reset tail", tail_bytes, 0);

    // fill the whole list with distinct singles; stale data for later
    for (int i = 0; i < 16; i++)
      do_op(1, 20'h00100 + 20'(i), 32'hA5A5_0000 + 32'(i), FULL, 0, 0, "R3 fill");
    // pointer at capacity: dropped
    do_op(1, 20'h00200, 32'h1234_5678, FULL, 0, 0, "R8 overflow");
    sbq.push_back(30); sbq.push_back(31);
    drain("R8 untouched");

    do_op(0, '0, '0, '0, 0, 1, "R10 clear");
    // same register as the last one before clear: no merge
    do_op(1, REG_A, 32'h0000_0011, FULL, 0, 0, "R7 fresh");
    do_op(1, REG_A, 32'h0000_0022, FULL, 0, 0, "R4 convert");
    do_op(1, REG_A, 32'h0000_0033, FULL, 0, 0, "R5 R6 append pad");
    do_op(1, REG_B, 32'h0000_0044, 32'h00FF_0F00, 0, 0, "R1 R2 masked odd ptr");
    do_op(1, REG_B, 32'h0000_0055, FULL, 0, 0, "R2 no join");
    do_op(1, REG_A, 32'h0000_0066, FULL, 0, 0, "R3 new reg");
    do_op(1, REG_C, 32'h0000_0070, 32'h8000_0001, 0, 0, "R1 lanes");
    do_op(1, REG_C, 32'h0000_0071, FULL, 0, 0, "R2 after masked");
    do_op(0, '0, '0, '0, 1, 0, "R9 aligned");
    do_op(1, REG_C, 32'h0000_0077, FULL, 0, 0, "R11 after finish");
    do_op(1, REG_C, 32'h0000_0088, FULL, 0, 0, "R4 convert2");
    do_op(1, REG_C, 32'h0000_0099, FULL, 0, 0, "R5 R6 count3");
    do_op(1, REG_C, 32'h0000_00AA, FULL, 0, 0, "R5 count4");
    do_op(0, '0, '0, '0, 1, 0, "R9 pad");

    do_op(1, REG_B, 32'h0000_00BB, FULL, 1, 1, "R10 clear wins");
    do_op(1, REG_A, 32'h0000_00CC, FULL, 0, 0, "R10 after clear");
    do_op(1, REG_A, 32'h0000_00DD, FULL, 1, 0, "R10 finish wins");
    do_op(0, '0, '0, '0, 1, 0, "R9 again aligned");
    do_op(0, '0, '0, '0, 0, 1, "R10 clear2");
    do_op(0, '0, '0, '0, 1, 0, "R9 empty");

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule